// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Logic

This block is the digital control core of a three-phase half-bridge driver. Each phase receives a high-side and a low-side command and produces two gate-enable outputs. The block blocks shoot-through, filters out short command pulses, and masks the gates when a fault occurs. It drives an active-low fault output.

Overcurrent forces all six gates off and asserts the fault. The fault stays in force for a programmable clear time after the overcurrent flag drops. A main-supply undervoltage also shuts down every gate and asserts the fault, but it releases the moment the flag clears. After that recovery, each phase keeps its high side off until its low side has been commanded on. A high-side supply undervoltage affects only the high side of that one phase, and it raises no fault.

The enable input is the sampled level of the pin that is shared with the fault indication. A low level disables every driver. The block's own fault also forces the drivers off, so the fault pulling that pin low can never leave a gate enabled. All asynchronous inputs pass through two-flop synchronizers.

Top module: `gate_protect`

## Requirements
- R1: Per phase, a filtered high command with the low command off drives only `gate_hi`, and a filtered low command with the high command off drives only `gate_lo`. Both on or both off gives both gates off. The two gates of one phase are never on together. After reset all gates are off and `fault_n` is 1.
- R2: While `oc_in` is asserted, all six gates are off and `fault_n` is 0 (from 3 clocks after assertion).
- R3: After `oc_in` drops, `fault_n` stays 0 and the gates stay off for CLR_CYCLES further cycles, then both release on their own. A new overcurrent during this countdown restarts the count.
- R4: While `uv_main_in` is asserted, all gates are off and `fault_n` is 0. Both release 3 clocks after the flag clears, with no clear-time delay.
- R5: After reset or after recovery from main-supply undervoltage, `gate_hi[p]` stays off until a filtered low-only command has been seen on phase p. Each phase re-arms independently of the others.
- R6: `uv_hs_in[p]` forces only `gate_hi[p]` off. It does not assert `fault_n`, and the gate recovers 3 clocks after the flag clears.
- R7: `en_pin_in` low forces all gates off without changing `fault_n`, and high lets them follow the commands again.
- R8: A command level takes effect only after it has been stable at the synchronizer output for FILT_CYCLES clocks. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 3 | High-side commands, bit p = phase p |
| cmd_lo | input | 3 | Low-side commands, bit p = phase p |
| oc_in | input | 1 | Overcurrent flag, active high |
| uv_main_in | input | 1 | Main-supply undervoltage flag, active high |
| uv_hs_in | input | 3 | Per-phase high-side supply undervoltage flags |
| en_pin_in | input | 1 | Sampled level of the shared enable/fault pin |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Fault output, 0 = fault |

## Verification
The bench builds the block with FILT_CYCLES = 4 and CLR_CYCLES = 50, in place of the microsecond-scale and millisecond-scale defaults. This puts the edge of the pulse filter within a few cycles, where a 2-cycle pulse is shown to be rejected. It also puts the whole overcurrent countdown, including a restart partway through, within a hundred cycles. With these values a behavioural model can follow every cycle of the re-arm, masking and clearing sequences.

// File: rtl/gate_protect.sv
module gate_protect #(
  parameter int FILT_CYCLES = 200,
  parameter int CLR_W       = 21,
  parameter int CLR_CYCLES  = 1800000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_hi,
  input  logic [2:0] cmd_lo,
  input  logic       oc_in,
  input  logic       uv_main_in,
  input  logic [2:0] uv_hs_in,
  input  logic       en_pin_in,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       fault_n
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int NI = 12;

  logic [NI-1:0] raw, s1, s2;
  assign raw = {en_pin_in, uv_main_in, oc_in, uv_hs_in, cmd_lo, cmd_hi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic [2:0] hi_s, lo_s, uvhs_s;
  logic       oc_s, uvm_s, en_s;
  assign {en_s, uvm_s, oc_s, uvhs_s, lo_s, hi_s} = s2;

  logic [5:0] cmd_f;
  genvar g;
  generate
    for (g = 0; g < 6; g++) begin : g_filt
      logic          lvl;
      logic [FW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          lvl <= 1'b0;
          cnt <= '0;
        end else if (s2[g] != lvl) begin
          if (cnt == FW'(FILT_CYCLES - 1)) begin
            lvl <= s2[g];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      assign cmd_f[g] = lvl;
    end
  endgenerate

  logic [2:0] hi_f, lo_f;
  assign hi_f = cmd_f[2:0];
  assign lo_f = cmd_f[5:3];

  logic             oc_hold;
  logic [CLR_W-1:0] clr_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_hold <= 1'b0;
      clr_cnt <= '0;
    end else if (oc_s) begin
      oc_hold <= 1'b1;
      clr_cnt <= '0;
    end else if (oc_hold) begin
      if (clr_cnt == CLR_W'(CLR_CYCLES - 1)) begin
        oc_hold <= 1'b0;
        clr_cnt <= '0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end

  logic [2:0] armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     armed <= '0;
    else if (uvm_s) armed <= '0;
    else            armed <= armed | (lo_f & ~hi_f);

  logic fault, drive_ok;
  assign fault    = oc_s | oc_hold | uvm_s;
  assign drive_ok = en_s & ~fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gate_hi <= '0;
      gate_lo <= '0;
      fault_n <= 1'b1;
    end else begin
      gate_hi <= hi_f & ~lo_f & {3{drive_ok}} & armed & ~uvhs_s;
      gate_lo <= lo_f & ~hi_f & {3{drive_ok}};
      fault_n <= ~fault;
    end
endmodule

module gate_protect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oc_in,
  input logic       uv_main_in,
  input logic [2:0] uv_hs_in,
  input logic       en_pin_in,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic       fault_n
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) (gate_hi & gate_lo) == 3'b000); // R1
  AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n) !fault_n |-> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R2
  AST_OC_FAULT: assert property (@(posedge clk) disable iff (!rst_n) ($past(oc_in, 1) && $past(oc_in, 2) && $past(oc_in, 3)) |-> !fault_n); // R2
  AST_UV_FAULT: assert property (@(posedge clk) disable iff (!rst_n) ($past(uv_main_in, 1) && $past(uv_main_in, 2) && $past(uv_main_in, 3)) |-> (!fault_n && gate_lo == 3'b000)); // R4
  AST_HS_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n) (($past(uv_hs_in, 1) & $past(uv_hs_in, 2) & $past(uv_hs_in, 3)) & gate_hi) == 3'b000); // R6
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!$past(en_pin_in, 1) && !$past(en_pin_in, 2) && !$past(en_pin_in, 3)) |-> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R7
endmodule

bind gate_protect gate_protect_chk u_chk (.*);

// File: tb/gate_protect_tb.sv
module gate_protect_tb;
  localparam int FILT = 4;
  localparam int CLR  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_hi = 3'b000, cmd_lo = 3'b000, uv_hs_in = 3'b000;
  logic oc_in = 1'b0, uv_main_in = 1'b0, en_pin_in = 1'b1;
  logic [2:0] gate_hi, gate_lo;
  logic fault_n;

  always #2.5 clk = ~clk;

  gate_protect #(.FILT_CYCLES(FILT), .CLR_W(8), .CLR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .oc_in(oc_in),
    .uv_main_in(uv_main_in), .uv_hs_in(uv_hs_in), .en_pin_in(en_pin_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n));

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference: a two-deep queue of input samples, integer counters
  logic [11:0] q[$];
  int  fcnt[6];
  bit  flvl[6];
  bit  hold;
  int  ccnt;
  bit  [2:0] arm, m_hi, m_lo;
  bit  m_fn;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {12'd0, 12'd0};
      foreach (fcnt[i]) begin fcnt[i] = 0; flvl[i] = 0; end
      hold = 0; ccnt = 0; arm = 0; m_hi = 0; m_lo = 0; m_fn = 1;
    end else begin
      logic [11:0] s;
      bit [2:0] fh, fl;
      bit ocs, uvm, en, flt;
      s = q[0];
      fh = {flvl[2], flvl[1], flvl[0]};
      fl = {flvl[5], flvl[4], flvl[3]};
      ocs = s[9]; uvm = s[10]; en = s[11];
      flt = ocs || hold || uvm;
      for (int p = 0; p < 3; p++) begin
        m_hi[p] = fh[p] && !fl[p] && en && !flt && arm[p] && !s[6+p];
        m_lo[p] = fl[p] && !fh[p] && en && !flt;
      end
      m_fn = !flt;
      if (uvm) arm = 0; else arm = arm | (fl & ~fh);
      if (ocs) begin hold = 1; ccnt = 0; end
      else if (hold) begin
        ccnt++;
        if (ccnt == CLR) begin hold = 0; ccnt = 0; end
      end
      for (int i = 0; i < 6; i++) begin
        if (s[i] != flvl[i]) begin
          fcnt[i]++;
          if (fcnt[i] == FILT) begin flvl[i] = s[i]; fcnt[i] = 0; end
        end else fcnt[i] = 0;
      end
      void'(q.pop_front());
      q.push_back({en_pin_in, uv_main_in, oc_in, uv_hs_in, cmd_lo, cmd_hi});
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (gate_hi !== m_hi || gate_lo !== m_lo || fault_n !== m_fn) begin
      fails++;
      $display("FAIL R1/R3/R5 model cycle: actual hi=%b lo=%b fn=%b expected hi=%b lo=%b fn=%b",
               gate_hi, gate_lo, fault_n, m_hi, m_lo, m_fn);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {hi,lo,fn}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    bit seen;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset state", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    cmd_hi = 3'b001; cyc(15);
    chk("R5 high side held until low seen", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    cmd_hi = 3'b000; cmd_lo = 3'b111; cyc(15);
    chk("R1 low only", {gate_hi, gate_lo, fault_n}, 7'b000_111_1);
    cmd_lo = 3'b000; cmd_hi = 3'b001; cyc(15);
    chk("R5 re-armed high only", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    cmd_hi = 3'b011; cmd_lo = 3'b010; cyc(15);
    chk("R1 both commands off", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    cmd_hi = 3'b001; cmd_lo = 3'b000; cyc(15);
    cmd_lo = 3'b100; cyc(2); cmd_lo = 3'b000;
    seen = 0;
    for (int i = 0; i < 14; i++) begin cyc(1); if (gate_lo[2]) seen = 1; end
    chk("R8 narrow pulse ignored", {6'b0, seen}, 7'b0);
    cmd_lo = 3'b100; cyc(14);
    chk("R8 wide pulse passed", {gate_hi, gate_lo, fault_n}, 7'b001_100_1);
    cmd_lo = 3'b000; cyc(14);
    uv_hs_in = 3'b001; cyc(6);
    chk("R6 hs undervoltage masks phase high", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    uv_hs_in = 3'b000; cyc(4);
    chk("R6 hs recovery immediate", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    en_pin_in = 1'b0; cyc(6);
    chk("R7 enable low", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    en_pin_in = 1'b1; cyc(6);
    chk("R7 enable high", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    oc_in = 1'b1; cyc(5);
    chk("R2 overcurrent shutdown", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
    oc_in = 1'b0; cyc(CLR - 10);
    chk("R3 still held during clear time", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
    cyc(20);
    chk("R3 auto release", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    oc_in = 1'b1; cyc(3); oc_in = 1'b0; cyc(30);
    oc_in = 1'b1; cyc(2); oc_in = 1'b0; cyc(CLR - 10);
    chk("R3 restart of countdown", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
    cyc(20);
    chk("R3 release after restart", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    uv_main_in = 1'b1; cyc(5);
    chk("R4 main undervoltage", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
    uv_main_in = 1'b0; cyc(4);
    chk("R4 immediate release, R5 high held", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    cmd_hi = 3'b000; cmd_lo = 3'b001; cyc(15);
    cmd_lo = 3'b000; cmd_hi = 3'b011; cyc(15);
    chk("R5 per-phase re-arm", {gate_hi, gate_lo, fault_n}, 7'b001_000_1);
    cyc(5);
    finish_run();
  end
endmodule